// File: doc/BRIEF.md
# Programmable Interface Latch Port

This block gives a line-card controller six general-purpose latch pins. Each pin can be made an input or an output. Two control registers, both written one byte at a time, set up the port. The direction register picks each pin's mode. The data register holds the levels that output pins drive. An input pin follows a level driven from outside, for example a loop-detect line from a subscriber interface circuit. That level passes through a synchronizer before the block uses it.

The serial control framing is reduced to strobes. A write strobe comes with a register select and the second byte of an instruction. A read strobe returns the data register's second byte. In that byte, pins in input mode show their sensed level and pins in output mode show their programmed level. The pad is modelled as a drive value plus an output-enable per pin. An enable of 0 stands for a high-impedance pin.

Top module: `iolatch_port`

## Requirements
- R1: While reset is held and in the first cycle after it ends, pin_oe and pin_out are all 0, rd_valid is 0 and rd_data is 0x00.
- R2: A write with wr_sel=0 loads the direction register. Pin k takes its direction from wr_byte bit 7-k (pin 0 at bit 7, pin 5 at bit 2), where 1 means output. The new value appears on pin_oe in the cycle after the strobe edge.
- R3: Bits 1 and 0 of wr_byte have no effect on either register.
- R4: A pin in output mode drives the data register bit for that pin on pin_out. A pin in input mode shows 0 on pin_out.
- R5: A write with wr_sel=1 stores all six data bits, using the same bit positions as R2, even for pins that are in input mode. A pin that later becomes an output drives the stored value at once.
- R6: A read strobe sets rd_valid for exactly one cycle, in the cycle after the strobe edge. rd_data keeps its value until the next read strobe.
- R7: rd_data uses the bit positions of R2. Each bit carries the programmed data value for an output pin, or the sensed level for an input pin. Bits 1 and 0 read as 0.
- R8: The sensed level passes through two flops. A pin_in change made before rising edge E is returned by a read strobe sampled at edge E+2. Read strobes sampled at E or E+1 still return the old level.
- R9: When a write and a read strobe occur in the same cycle, the read returns the register state from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 1 | Register select: 0 direction, 1 data |
| wr_byte | input | 8 | Second instruction byte |
| rd_en | input | 1 | Data register read strobe |
| rd_data | output | 8 | Readback byte |
| rd_valid | output | 1 | One-cycle pulse when rd_data is refreshed |
| pin_in | input | 6 | External levels seen at the pins |
| pin_out | output | 6 | Drive value per pin |
| pin_oe | output | 6 | Output enable per pin (0 = high impedance) |

## Verification
A corrupt direction bit shows on pin_oe in the cycle after the write that caused it. It also shows on pin_out and in the next readback, where the wrong source is selected for that bit. A corrupt stored data bit stays hidden while its pin is an input, and it appears as soon as the pin is switched to output. So the bench writes data first and changes direction afterwards. A synchronizer that is too short or too long moves the readback of a changed input by one edge. The latency test reads on three consecutive edges to pin down when the change first appears.

// File: rtl/iolatch_pkg.sv
package iolatch_pkg;

    localparam int unsigned LATCH_PINS  = 6;
    localparam int unsigned CTRL_BYTE_W = 8;
    localparam int unsigned SYNC_DEPTH  = 2;

    typedef enum logic {
        SEL_DIR  = 1'b0,
        SEL_DATA = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic                    valid;
        reg_sel_e                sel;
        logic [CTRL_BYTE_W-1:0]  payload;
    } ctrl_wr_t;

endpackage

// File: rtl/iolatch_sync.sv
module iolatch_sync #(
    parameter int unsigned WIDTH  = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d;
    end

    for (genvar i = 1; i < int'(STAGES); i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[i] <= '0;
            else     stage_q[i] <= stage_q[i-1];
        end

        // R8: each stage advances by exactly one edge
        a_r8_stage_shift: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> stage_q[i] == $past(stage_q[i-1]));
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/iolatch_regs.sv
module iolatch_regs
    import iolatch_pkg::*;
#(
    parameter int unsigned NUM_PINS = LATCH_PINS,
    parameter int unsigned BYTE_W   = CTRL_BYTE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  ctrl_wr_t            cmd,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] data_q
);

    localparam int unsigned PAD_W = BYTE_W - NUM_PINS;

    logic [NUM_PINS-1:0] field;
    logic [PAD_W-1:0]    unused_pad;

    // pin k sits at byte bit BYTE_W-1-k
    for (genvar k = 0; k < int'(NUM_PINS); k++) begin : g_unpack
        assign field[k] = cmd.payload[BYTE_W-1-k];
    end
    assign unused_pad = cmd.payload[PAD_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            data_q <= '0;
        end else if (cmd.valid) begin
            if (cmd.sel == SEL_DIR) dir_q  <= field;
            else                    data_q <= field;
        end
    end

    // R5: data register changes only on a data write
    a_r5_data_keep: assert property (@(posedge clk) disable iff (rst)
        !(cmd.valid && cmd.sel == SEL_DATA) |=> $stable(data_q));

    // R2: direction register changes only on a direction write
    a_r2_dir_keep: assert property (@(posedge clk) disable iff (rst)
        !(cmd.valid && cmd.sel == SEL_DIR) |=> $stable(dir_q));

endmodule

// File: rtl/iolatch_readback.sv
module iolatch_readback #(
    parameter int unsigned NUM_PINS = 6,
    parameter int unsigned BYTE_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_en,
    input  logic [NUM_PINS-1:0] dir_q,
    input  logic [NUM_PINS-1:0] data_q,
    input  logic [NUM_PINS-1:0] sensed,
    output logic [BYTE_W-1:0]   rd_data,
    output logic                rd_valid
);

    localparam int unsigned PAD_W = BYTE_W - NUM_PINS;

    logic [NUM_PINS-1:0] mixed;
    logic [BYTE_W-1:0]   packed_byte;

    assign mixed = (dir_q & data_q) | (~dir_q & sensed);

    for (genvar k = 0; k < int'(NUM_PINS); k++) begin : g_pack
        assign packed_byte[BYTE_W-1-k] = mixed[k];
    end
    assign packed_byte[PAD_W-1:0] = '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= packed_byte;
        end
    end

    // R6: readback held between read strobes
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R6: valid follows the strobe by one edge
    a_r6_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R7: pad bits never read as 1
    a_r7_pad_zero: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> rd_data[PAD_W-1:0] == '0);

endmodule

// File: rtl/iolatch_port.sv
module iolatch_port
    import iolatch_pkg::*;
#(
    parameter int unsigned NUM_PINS    = LATCH_PINS,
    parameter int unsigned BYTE_W      = CTRL_BYTE_W,
    parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [BYTE_W-1:0]   wr_byte,
    input  logic                rd_en,
    output logic [BYTE_W-1:0]   rd_data,
    output logic                rd_valid,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);

    ctrl_wr_t            cmd;
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] data_q;
    logic [NUM_PINS-1:0] sensed;

    assign cmd.valid   = wr_en;
    assign cmd.sel     = reg_sel_e'(wr_sel);
    assign cmd.payload = wr_byte;

    iolatch_regs #(
        .NUM_PINS (NUM_PINS),
        .BYTE_W   (BYTE_W)
    ) regs_i (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .dir_q  (dir_q),
        .data_q (data_q)
    );

    iolatch_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (sensed)
    );

    iolatch_readback #(
        .NUM_PINS (NUM_PINS),
        .BYTE_W   (BYTE_W)
    ) rdbk_i (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .dir_q    (dir_q),
        .data_q   (data_q),
        .sensed   (sensed),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign pin_oe  = dir_q;
    assign pin_out = data_q & dir_q;

    // R1: port comes out of reset with every pin released
    a_r1_reset_released: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_oe == '0 && pin_out == '0 && !rd_valid));

    // R2: direction write shows on pin_oe next cycle
    for (genvar k = 0; k < int'(NUM_PINS); k++) begin : g_chk
        a_r2_dir_load: assert property (@(posedge clk) disable iff (rst)
            (wr_en && !wr_sel) |=> pin_oe[k] == $past(wr_byte[BYTE_W-1-k]));

        // R7: output pins read back the value they drive
        a_r7_out_readback: assert property (@(posedge clk) disable iff (rst)
            (rd_en && pin_oe[k]) |=> rd_data[BYTE_W-1-k] == $past(pin_out[k]));
    end

endmodule

// File: tb/iolatch_port_tb.sv
module iolatch_port_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_byte = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic [5:0] pin_in = '0;
    logic [5:0] pin_out;
    logic [5:0] pin_oe;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [5:0] dir_m = '0;
    logic [5:0] data_m = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iolatch_port dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_byte(wr_byte), .rd_en(rd_en), .rd_data(rd_data),
        .rd_valid(rd_valid), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe)
    );

    function automatic logic [7:0] pack6(input logic [5:0] v);
        logic [7:0] b = '0;
        for (int k = 0; k < 6; k++) b[7-k] = v[k];
        return b;
    endfunction

    function automatic logic [5:0] unpack6(input logic [7:0] b);
        logic [5:0] v;
        for (int k = 0; k < 6; k++) v[k] = b[7-k];
        return v;
    endfunction

    function automatic logic [7:0] exp_read(input logic [5:0] d,
                                            input logic [5:0] q,
                                            input logic [5:0] s);
        return pack6((d & q) | (~d & s));
    endfunction

    task automatic check(input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic sel, input logic [7:0] b);
        wr_en = 1'b1; wr_sel = sel; wr_byte = b;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) data_m = unpack6(b);
        else     dir_m  = unpack6(b);
    endtask

    task automatic do_read();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        repeat (4) @(negedge clk);
        check("R1 oe in reset", {2'b0, pin_oe}, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R1 oe", {2'b0, pin_oe}, 8'h00);
        check("R1 out", {2'b0, pin_out}, 8'h00);
        check("R1 valid", {7'b0, rd_valid}, 8'h00);
        check("R1 rdata", rd_data, 8'h00);

        // R2 bit mapping: only pin 0 (bit 7)
        do_write(1'b0, 8'h80);
        check("R2 pin0 only", {2'b0, pin_oe}, 8'h01);
        // R3 low bits on direction ignored
        do_write(1'b0, 8'h03);
        check("R3 dir pad", {2'b0, pin_oe}, 8'h00);

        // all outputs, data with pad bits set
        do_write(1'b0, 8'hFF);
        check("R2 all out", {2'b0, pin_oe}, 8'h3F);
        do_write(1'b1, 8'hFF);
        check("R4 all drive", {2'b0, pin_out}, 8'h3F);
        do_read();
        check("R3 R7 pad reads 0", rd_data, 8'hFC);
        check("R6 valid", {7'b0, rd_valid}, 8'h01);
        @(negedge clk);
        check("R6 one pulse", {7'b0, rd_valid}, 8'h00);
        check("R6 held", rd_data, 8'hFC);

        // R5 data stored while pins are inputs
        do_write(1'b0, 8'h00);
        do_write(1'b1, 8'hA8);
        check("R4 inputs drive 0", {2'b0, pin_out}, 8'h00);
        do_write(1'b0, 8'hFC);
        check("R5 stored appears", {2'b0, pin_out}, 8'h15);

        // R8 latency: all inputs, change pin_in with reads on three edges
        do_write(1'b0, 8'h00);
        pin_in = 6'h00;
        settle();
        pin_in = 6'h3F;
        rd_en = 1'b1;
        @(negedge clk);
        check("R8 edge E", rd_data, 8'h00);
        @(negedge clk);
        check("R8 edge E+1", rd_data, 8'h00);
        @(negedge clk);
        check("R8 edge E+2", rd_data, 8'hFC);
        rd_en = 1'b0;

        // R9 write and read in same cycle
        do_write(1'b0, 8'hFC);
        do_write(1'b1, 8'h00);
        wr_en = 1'b1; wr_sel = 1'b1; wr_byte = 8'hFC; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; data_m = 6'h3F;
        check("R9 pre-write read", rd_data, 8'h00);
        check("R9 write landed", {2'b0, pin_out}, 8'h3F);
        do_read();
        check("R9 next read", rd_data, 8'hFC);

        // random mix
        for (int it = 0; it < 300; it++) begin
            int op = $urandom_range(0, 3);
            if (op == 0 || op == 3) do_write(1'b0, 8'($urandom));
            if (op == 1 || op == 3) do_write(1'b1, 8'($urandom));
            if (op == 2 || $urandom_range(0, 1) == 1) pin_in = 6'($urandom);
            settle();
            check("R2 rand oe", {2'b0, pin_oe}, {2'b0, dir_m});
            check("R4 rand out", {2'b0, pin_out}, {2'b0, dir_m & data_m});
            do_read();
            check("R7 rand read", rd_data, exp_read(dir_m, data_m, pin_in));
        end

        finish_run();
    end

endmodule